// File: doc/BRIEF.md
# Adder-Subtractor With Status Flags

This block is a purely combinational arithmetic unit of parameterised width. It takes two operands and a two-bit operation code, and it produces a sum or difference together with three status bits. Every operation runs through one shared parallel adder. A selector in front of the adder's second input chooses that input and the carry-in, so a single carry chain serves all four operations. Subtraction is done as addition of the two's complement: the second operand is inverted and the carry-in is set.

The status bits are the raw carry-out of the adder and a signed overflow flag. The overflow flag is the XOR of the carry into the sign bit and the carry out of it. The third bit is an unsigned borrow indication, which is the inverted carry-out on the subtracting operations and zero otherwise. Signed operands use two's complement, with the most significant bit as the sign: 0 means non-negative and 1 means negative.

The block has no clock, no reset and no state. Its outputs follow its inputs within the same cycle. It is meant to sit inside a datapath stage whose registers belong to the surrounding logic.

Top module: `addsub_unit`

## Requirements
- R1: With op_i = 2'b00 (add), res_o equals (a_i + b_i) mod 2^WIDTH and carry_o equals bit WIDTH of the full sum.
- R2: With op_i = 2'b01 (subtract), res_o equals (a_i - b_i) mod 2^WIDTH and carry_o is 1 exactly when a_i >= b_i as unsigned numbers.
- R3: ovf_o is 1 exactly when the signed two's-complement result of the selected operation lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1. This includes the most negative value minus 1 and the largest positive value plus 1.
- R4: With op_i = 2'b01, borrow_o is 1 exactly when a_i < b_i as unsigned numbers.
- R5: With op_i = 2'b10 (increment), res_o equals (a_i + 1) mod 2^WIDTH, carry_o is 1 only for an all-ones a_i, and b_i has no effect on any output.
- R6: With op_i = 2'b11 (decrement), res_o equals (a_i - 1) mod 2^WIDTH, carry_o is 0 and borrow_o is 1 only for a_i = 0, and b_i has no effect on any output.
- R7: borrow_o is 0 whenever op_i selects add or increment.
- R8: The block holds no state. Each output is a function of the present inputs alone and settles in the same cycle that the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 increment, 11 decrement |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, used by add and subtract only |
| res_o | output | WIDTH | Result of the selected operation |
| carry_o | output | 1 | Carry out of the sign position |
| ovf_o | output | 1 | Signed overflow |
| borrow_o | output | 1 | Unsigned borrow on subtract and decrement |

## Verification
Two flags can rise in the same evaluation. Carry-out and signed overflow can both be set on an add. Borrow and signed overflow can both be set on a subtract. The bench provokes both pairings on purpose. One case adds the most negative value to itself. Another subtracts the most negative value from the largest positive one. A third adds -1 to the most negative value. In each case every flag is compared separately against values from a reference model built on integer arithmetic. That reference is then swept over a grid of operands in all four operations, so a flag that is correct alone but wrong in combination with another still shows up.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } asu_op_e;

    // The operations that reuse the adder to take something away.
    function automatic logic op_takes_away(input asu_op_e op);
        return (op == OP_SUB) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/addsub_bsel.sv
module addsub_bsel
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  asu_op_e          op,
    input  logic [WIDTH-1:0] b_raw,
    output logic [WIDTH-1:0] b_eff,
    output logic             cin
);

    // Four choices for the adder's second input; carry-in completes each operation.
    always_comb begin
        unique case (op)
            OP_ADD: begin b_eff = b_raw;            cin = 1'b0; end
            OP_SUB: begin b_eff = ~b_raw;           cin = 1'b1; end
            OP_INC: begin b_eff = '0;               cin = 1'b1; end
            OP_DEC: begin b_eff = {WIDTH{1'b1}};    cin = 1'b0; end
            default: begin b_eff = b_raw;           cin = 1'b0; end
        endcase
    end

    always_comb begin
        if (!$isunknown(op)) begin
            p_inc_dec_ignore_b_r5: assert (!(op == OP_INC || op == OP_DEC) ||
                                           (b_eff == '0 || b_eff == {WIDTH{1'b1}}))
                else $error("p_inc_dec_ignore_b_r5");
        end
    end

endmodule

// File: rtl/addsub_fa.sv
module addsub_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    logic half;

    always_comb begin
        half = x ^ y;
        s    = half ^ ci;
        co   = (x & y) | (half & ci);
    end

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             c_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        addsub_fa u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (c[i]),
            .s  (sum[i]),
            .co (c[i+1])
        );
    end

    assign c_into_msb = c[MSB];
    assign c_out      = c[WIDTH];

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
(
    input  asu_op_e op,
    input  logic    c_into_msb,
    input  logic    c_out,
    output logic    carry,
    output logic    ovf,
    output logic    borrow
);

    always_comb begin
        carry  = c_out;
        ovf    = c_into_msb ^ c_out;
        borrow = op_takes_away(op) & ~c_out;
    end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             borrow_o
);

    localparam int MSB = WIDTH - 1;

    asu_op_e          op;
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [WIDTH-1:0] sum;
    logic             c_into_msb;
    logic             c_out;

    assign op = asu_op_e'(op_i);

    addsub_bsel #(.WIDTH(WIDTH)) u_bsel (
        .op    (op),
        .b_raw (b_i),
        .b_eff (b_eff),
        .cin   (cin)
    );

    addsub_chain #(.WIDTH(WIDTH)) u_chain (
        .x          (a_i),
        .y          (b_eff),
        .cin        (cin),
        .sum        (sum),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    addsub_flags u_flags (
        .op         (op),
        .c_into_msb (c_into_msb),
        .c_out      (c_out),
        .carry      (carry_o),
        .ovf        (ovf_o),
        .borrow     (borrow_o)
    );

    assign res_o = sum;

    // Port-level checks relating the operands to the flags and result.
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, res_o, carry_o, ovf_o, borrow_o})) begin
            p_add_sum_r1: assert (op != OP_ADD ||
                                  {carry_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("p_add_sum_r1");
            p_sub_carry_r2: assert (op != OP_SUB || carry_o == (a_i >= b_i))
                else $error("p_sub_carry_r2");
            p_add_ovf_sign_r3: assert (op != OP_ADD ||
                                       ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
                else $error("p_add_ovf_sign_r3");
            p_sub_ovf_sign_r3: assert (op != OP_SUB ||
                                       ovf_o == ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
                else $error("p_sub_ovf_sign_r3");
            p_sub_borrow_r4: assert (op != OP_SUB || borrow_o == (a_i < b_i))
                else $error("p_sub_borrow_r4");
            p_dec_borrow_r6: assert (op != OP_DEC || borrow_o == (a_i == '0))
                else $error("p_dec_borrow_r6");
            p_borrow_quiet_r7: assert (!(op == OP_ADD || op == OP_INC) || !borrow_o)
                else $error("p_borrow_quiet_r7");
        end
    end

endmodule

// File: tb/tb_addsub_unit.sv
`timescale 1ns/1ps
module tb_addsub_unit;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic [1:0]   op  = 2'b00;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [W-1:0] res;
    logic         carry, ovf, borrow;
    logic         rst_n = 1'b0;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    addsub_unit #(.WIDTH(W)) dut (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .res_o    (res),
        .carry_o  (carry),
        .ovf_o    (ovf),
        .borrow_o (borrow)
    );

    // {op, a, b, res, carry, ovf, borrow}
    localparam int VN = 15;
    localparam logic [28:0] VEC [VN] = '{
        {2'b00, 8'h03, 8'h05, 8'h08, 1'b0, 1'b0, 1'b0},  // R1 plain add
        {2'b00, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0},  // R1 carry, R7
        {2'b00, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 1'b0},  // R3 max+1
        {2'b00, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1, 1'b0},  // R3 carry and ovf
        {2'b00, 8'h80, 8'hFF, 8'h7F, 1'b1, 1'b1, 1'b0},  // R3 min + -1
        {2'b01, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0, 1'b0},  // R2
        {2'b01, 8'h03, 8'h05, 8'hFE, 1'b0, 1'b0, 1'b1},  // R4 borrow
        {2'b01, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1, 1'b0},  // R3 min-1
        {2'b01, 8'h7F, 8'h80, 8'hFF, 1'b0, 1'b1, 1'b1},  // R3 R4 borrow and ovf
        {2'b01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R2 equal operands
        {2'b10, 8'h7F, 8'h55, 8'h80, 1'b0, 1'b1, 1'b0},  // R5 inc overflow
        {2'b10, 8'hFF, 8'hAA, 8'h00, 1'b1, 1'b0, 1'b0},  // R5 inc wrap
        {2'b11, 8'h00, 8'h33, 8'hFF, 1'b0, 1'b0, 1'b1},  // R6 dec of zero
        {2'b11, 8'h80, 8'hCC, 8'h7F, 1'b1, 1'b1, 1'b0},  // R6 dec of min
        {2'b11, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0}   // R6
    };

    function automatic logic [W+2:0] ref_model(input logic [1:0] o,
                                               input logic [W-1:0] x,
                                               input logic [W-1:0] y);
        int ux, uy, sx, sy, ur, sr;
        logic c, v, w;
        ux = int'(x);
        uy = int'(y);
        sx = (ux >= 128) ? ux - 256 : ux;
        sy = (uy >= 128) ? uy - 256 : uy;
        c = 1'b0; w = 1'b0; ur = 0; sr = 0;
        case (o)
            2'b00: begin ur = ux + uy; sr = sx + sy; c = (ur > 255); end
            2'b01: begin ur = ux - uy; sr = sx - sy; c = (ux >= uy); w = (ux < uy); end
            2'b10: begin ur = ux + 1;  sr = sx + 1;  c = (ur > 255); end
            default: begin ur = ux - 1; sr = sx - 1; c = (ux != 0); w = (ux == 0); end
        endcase
        v = (sr > 127) || (sr < -128);
        return {ur[W-1:0], c, v, w};
    endfunction

    task automatic check(input string req, input logic [W+2:0] exp);
        n_vec++;
        if ({res, carry, ovf, borrow} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h: got res=%h c=%b v=%b w=%b, expected res=%h c=%b v=%b w=%b",
                     req, op, a, b, res, carry, ovf, borrow,
                     exp[W+2:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R8: all-zero inputs after reset give all-zero outputs in the same cycle
        #1;
        check("R8 reset", '0);

        for (int i = 0; i < VN; i++) begin
            apply(VEC[i][28:27], VEC[i][26:19], VEC[i][18:11]);
            check("R1-table", VEC[i][10:0]);
        end

        // Reference sweep over all operations (R1 R2 R3 R4 R5 R6 R7)
        for (int o = 0; o < 4; o++) begin
            for (int x = 0; x < 256; x += 17) begin
                for (int y = 0; y < 256; y += 15) begin
                    apply(2'(o), 8'(x), 8'(y));
                    check((o == 0) ? "R1 R3 R7" : (o == 1) ? "R2 R3 R4" :
                          (o == 2) ? "R5 R7" : "R6", ref_model(2'(o), 8'(x), 8'(y)));
                end
            end
        end

        // R5 R6: changing only b under inc/dec leaves every output unchanged
        for (int k = 0; k < 4; k++) begin
            apply(2'b10, 8'h41, 8'(k * 85));
            check("R5 b ignored", {8'h42, 1'b0, 1'b0, 1'b0});
            apply(2'b11, 8'h41, 8'(k * 85));
            check("R6 b ignored", {8'h40, 1'b1, 1'b0, 1'b0});
        end

        // R8: output follows an input change with no clock edge in between
        @(negedge clk);
        op = 2'b00; a = 8'h10; b = 8'h20;
        #0.5;
        check("R8 same-cycle", {8'h30, 1'b0, 1'b0, 1'b0});
        a = 8'h7F; b = 8'h7F;
        #0.5;
        check("R8 same-cycle", {8'hFE, 1'b0, 1'b1, 1'b0});

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule